// File: doc/BRIEF.md
# Four-Bit Accumulator Processor Core

This block is a small multicycle processor with a four-bit data path and an eight-bit address space. It keeps an accumulator, an index register, an operand holding register, a memory address register, a program counter and a zero flag. A state machine fetches a one-nibble opcode and then the operand nibbles that follow it. It then performs one load, store, add, NAND, index, branch or output operation.

Program memory occupies the lower half of the address space and data memory the upper half. Both memories sit outside the core. The core reads a nibble in the same cycle it presents the address, and it writes with a strobe while it drives the data bus. A separate four-bit output register feeds a peripheral and changes only on the two output instructions.

Top module: `nib_cpu_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0x00 and clears the accumulator, the index register, the zero flag and the output register. The first cycle after reset reads address 0x00 with `rd_o` high and `wr_o` low.
- R2: Opcode 0000 loads the following nibble into the accumulator. Opcode 0011 adds the following nibble to the accumulator modulo 16.
- R3: Opcode 1000 sets the accumulator to NOT(accumulator AND following nibble). Opcode 0101 does the same with the memory nibble at the indexed address.
- R4: Direct instructions carry two address nibbles after the opcode, high nibble first. Opcode 0001 loads the accumulator from that address. Opcode 0110 writes the accumulator there. Opcode 1100 writes the index register there.
- R5: Indexed instructions (0010 load, 0100 add, 0101 NAND, 0111 output) use the two-nibble base address plus the zero-extended index register, modulo 256.
- R6: Every write to the accumulator sets the zero flag when the result is 0000 and clears it otherwise. Opcode 1111 jumps to its two-nibble target only when the flag is set; otherwise execution continues after its operands.
- R7: Opcode 1110 always jumps to its two-nibble target address.
- R8: Opcode 1010 loads the following nibble into the index register. Opcode 1011 loads the index register from a direct address. Opcode 1101 adds the following nibble to the index register modulo 16.
- R9: Opcode 1001 copies the following nibble to `out_o`. Opcode 0111 copies the indexed memory nibble to `out_o`. `out_o` holds its value through all other instructions.
- R10: `rd_o` and `wr_o` are never high together. `data_oe_o` is high whenever `wr_o` is high. A write drives the stored register onto `data_o` at `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_o | output | 8 | Address bus |
| data_i | input | 4 | Read data from memory, sampled on the read cycle |
| data_o | output | 4 | Write data to memory |
| data_oe_o | output | 1 | Data bus drive enable |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| out_o | output | 4 | Peripheral output register |

## Verification
Internal state surfaces at the ports only through stores, output updates and the flow of fetch addresses. A wrong accumulator, index or flag value is therefore seen at the next store, output instruction or conditional branch, usually a few instructions later. The test program saves every intermediate result to data memory. It places unreachable output instructions on the wrong side of each branch, so a faulty branch decision shows as an unexpected `out_o` change. A scoreboard compares the ordered stream of writes and output changes, so a misplaced or extra bus write is reported in the cycle it occurs.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;

    localparam int DW = 4;
    localparam int AW = 2 * DW;

    typedef enum logic [DW-1:0] {
        OP_LDAI  = 4'b0000,
        OP_LDAD  = 4'b0001,
        OP_LDAX  = 4'b0010,
        OP_ADDI  = 4'b0011,
        OP_ADDX  = 4'b0100,
        OP_NANDX = 4'b0101,
        OP_STAD  = 4'b0110,
        OP_OUTX  = 4'b0111,
        OP_NANDI = 4'b1000,
        OP_OUTI  = 4'b1001,
        OP_LDXI  = 4'b1010,
        OP_LDXD  = 4'b1011,
        OP_STXD  = 4'b1100,
        OP_UDXI  = 4'b1101,
        OP_BRA   = 4'b1110,
        OP_BEQ   = 4'b1111
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_IMM, ST_AHI, ST_ALO, ST_IDX, ST_MRD, ST_MWR, ST_EXEC
    } state_e;

    typedef enum logic [1:0] { AM_IMM, AM_DIR, AM_IDX, AM_BR } amode_e;
    typedef enum logic [1:0] { ALU_PASS, ALU_ADD, ALU_NAND } alu_op_e;
    typedef enum logic [1:0] { DST_NONE, DST_A, DST_X, DST_OUT } dest_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic addr_pc;
        logic pc_inc;
        logic pc_jump;
        logic ir_ld;
        logic b_ld;
        logic mar_hi_ld;
        logic mar_lo_ld;
        logic mar_idx;
        logic exec;
    } ctl_t;

    function automatic amode_e mode_of(opcode_e op);
        case (op)
            OP_LDAD, OP_STAD, OP_LDXD, OP_STXD:   return AM_DIR;
            OP_LDAX, OP_ADDX, OP_NANDX, OP_OUTX:  return AM_IDX;
            OP_BRA, OP_BEQ:                       return AM_BR;
            default:                              return AM_IMM;
        endcase
    endfunction

    function automatic logic is_store(opcode_e op);
        return (op == OP_STAD) || (op == OP_STXD);
    endfunction

    function automatic alu_op_e alu_of(opcode_e op);
        case (op)
            OP_ADDI, OP_ADDX, OP_UDXI: return ALU_ADD;
            OP_NANDI, OP_NANDX:        return ALU_NAND;
            default:                   return ALU_PASS;
        endcase
    endfunction

    function automatic dest_e dest_of(opcode_e op);
        case (op)
            OP_LDAI, OP_LDAD, OP_LDAX, OP_ADDI,
            OP_ADDX, OP_NANDI, OP_NANDX:          return DST_A;
            OP_LDXI, OP_LDXD, OP_UDXI:            return DST_X;
            OP_OUTI, OP_OUTX:                     return DST_OUT;
            default:                              return DST_NONE;
        endcase
    endfunction

endpackage

// File: rtl/nib_cpu_alu.sv
module nib_cpu_alu
    import nib_cpu_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    output logic [DW-1:0] y,
    output logic          zero
);
    always_comb begin
        case (op)
            ALU_ADD:  y = lhs + rhs;
            ALU_NAND: y = ~(lhs & rhs);
            default:  y = rhs;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/nib_cpu_ctrl.sv
module nib_cpu_ctrl
    import nib_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_e fetched,
    input  opcode_e ir,
    input  logic    zf,
    output state_e  st,
    output ctl_t    ctl
);
    state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_FETCH;
        else     st_q <= st_d;
    end

    always_comb begin
        ctl  = '0;
        st_d = st_q;
        case (st_q)
            ST_FETCH: begin
                ctl.rd = 1'b1; ctl.addr_pc = 1'b1;
                ctl.ir_ld = 1'b1; ctl.pc_inc = 1'b1;
                st_d = (mode_of(fetched) == AM_IMM) ? ST_IMM : ST_AHI;
            end
            ST_IMM: begin
                ctl.rd = 1'b1; ctl.addr_pc = 1'b1;
                ctl.b_ld = 1'b1; ctl.pc_inc = 1'b1;
                st_d = ST_EXEC;
            end
            ST_AHI: begin
                ctl.rd = 1'b1; ctl.addr_pc = 1'b1;
                ctl.mar_hi_ld = 1'b1; ctl.pc_inc = 1'b1;
                st_d = ST_ALO;
            end
            ST_ALO: begin
                ctl.rd = 1'b1; ctl.addr_pc = 1'b1; ctl.pc_inc = 1'b1;
                if (mode_of(ir) == AM_BR) begin
                    ctl.pc_jump = (ir == OP_BRA) || zf;
                    st_d = ST_FETCH;
                end else begin
                    ctl.mar_lo_ld = 1'b1;
                    if (mode_of(ir) == AM_IDX) st_d = ST_IDX;
                    else if (is_store(ir))     st_d = ST_MWR;
                    else                       st_d = ST_MRD;
                end
            end
            ST_IDX: begin
                ctl.mar_idx = 1'b1;
                st_d = ST_MRD;
            end
            ST_MRD: begin
                ctl.rd = 1'b1; ctl.b_ld = 1'b1;
                st_d = ST_EXEC;
            end
            ST_MWR: begin
                ctl.wr = 1'b1;
                st_d = ST_FETCH;
            end
            default: begin
                ctl.exec = 1'b1;
                st_d = ST_FETCH;
            end
        endcase
    end

    assign st = st_q;
endmodule

// File: rtl/nib_cpu_core.sv
module nib_cpu_core
    import nib_cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] addr_o,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o,
    output logic          data_oe_o,
    output logic          rd_o,
    output logic          wr_o,
    output logic [DW-1:0] out_o
);
    logic [AW-1:0] pc_q, mar_q;
    logic [DW-1:0] a_q, b_q, x_q, out_q;
    logic          zf_q;
    opcode_e       ir_q;
    state_e        st;
    ctl_t          ctl;
    dest_e         dest;
    logic [DW-1:0] alu_y;
    logic          alu_zero;

    nib_cpu_ctrl ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .fetched (opcode_e'(data_i)),
        .ir      (ir_q),
        .zf      (zf_q),
        .st      (st),
        .ctl     (ctl)
    );

    assign dest = dest_of(ir_q);

    nib_cpu_alu alu_i (
        .op   (alu_of(ir_q)),
        .lhs  ((dest == DST_X) ? x_q : a_q),
        .rhs  (b_q),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            x_q   <= '0;
            out_q <= '0;
            zf_q  <= 1'b0;
            ir_q  <= OP_LDAI;
        end else begin
            if (ctl.ir_ld)     ir_q <= opcode_e'(data_i);
            if (ctl.pc_jump)   pc_q <= {mar_q[AW-1:DW], data_i};
            else if (ctl.pc_inc) pc_q <= pc_q + 1'b1;
            if (ctl.b_ld)      b_q <= data_i;
            if (ctl.mar_hi_ld) mar_q[AW-1:DW] <= data_i;
            if (ctl.mar_lo_ld) mar_q[DW-1:0]  <= data_i;
            if (ctl.mar_idx)   mar_q <= mar_q + AW'(x_q);
            if (ctl.exec) begin
                case (dest)
                    DST_A: begin
                        a_q  <= alu_y;
                        zf_q <= alu_zero;
                    end
                    DST_X:   x_q   <= alu_y;
                    DST_OUT: out_q <= b_q;
                    default: ;
                endcase
            end
        end
    end

    assign addr_o    = ctl.addr_pc ? pc_q : mar_q;
    assign data_o    = (ir_q == OP_STXD) ? x_q : a_q;
    assign data_oe_o = ctl.wr;
    assign wr_o      = ctl.wr;
    assign rd_o      = ctl.rd;
    assign out_o     = out_q;
endmodule

// File: rtl/nib_cpu_chk.sv
module nib_cpu_chk
    import nib_cpu_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr_o,
    input logic [DW-1:0] data_i,
    input logic          data_oe_o,
    input logic          rd_o,
    input logic          wr_o,
    input logic [DW-1:0] out_o,
    input state_e        st,
    input opcode_e       ir_q,
    input logic [DW-1:0] a_q,
    input logic [DW-1:0] b_q,
    input logic [DW-1:0] x_q,
    input logic          zf_q,
    input logic [AW-1:0] mar_q
);
    p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (addr_o == '0 && rd_o && !wr_o));

    p_rw_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(rd_o && wr_o));

    p_write_drives_r10: assert property (@(posedge clk) disable iff (rst)
        wr_o |-> data_oe_o);

    p_zero_tracks_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(a_q) |-> (zf_q == (a_q == '0)));

    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_o) |-> ($past(st) == ST_EXEC &&
                             ($past(ir_q) == OP_OUTI || $past(ir_q) == OP_OUTX)));

    p_index_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXEC && ir_q == OP_UDXI) |=> (x_q == DW'($past(x_q) + $past(b_q))));

    p_index_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDX) |=> (addr_o == AW'($past(mar_q) + AW'($past(x_q)))));

    p_branch_always_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ALO && ir_q == OP_BRA) |=>
            (addr_o == {$past(mar_q[AW-1:DW]), $past(data_i)}));
endmodule

bind nib_cpu_core nib_cpu_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .addr_o    (addr_o),
    .data_i    (data_i),
    .data_oe_o (data_oe_o),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .out_o     (out_o),
    .st        (st),
    .ir_q      (ir_q),
    .a_q       (a_q),
    .b_q       (b_q),
    .x_q       (x_q),
    .zf_q      (zf_q),
    .mar_q     (mar_q)
);

// File: tb/nib_cpu_core_tb_top.sv
module nib_cpu_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 3000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr_o;
    logic [3:0] data_i, data_o, out_o;
    logic       data_oe_o, rd_o, wr_o;

    logic [3:0] mem [256];
    int         checks = 0;
    int         failures = 0;
    logic       running = 1'b0;
    logic [3:0] prev_out;
    logic [7:0] ptr;

    typedef struct {
        bit         is_out;
        logic [7:0] addr;
        logic [3:0] data;
        string      req;
    } exp_t;
    exp_t exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_cpu_core dut_i (
        .clk(clk), .rst(rst), .addr_o(addr_o), .data_i(data_i),
        .data_o(data_o), .data_oe_o(data_oe_o), .rd_o(rd_o),
        .wr_o(wr_o), .out_o(out_o)
    );

    assign data_i = mem[addr_o];

    always @(posedge clk) begin
        if (wr_o && addr_o[7]) mem[addr_o] <= data_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push_exp(input bit is_out, input logic [7:0] a,
                            input logic [3:0] d, input string req);
        exp_t e;
        e.is_out = is_out; e.addr = a; e.data = d; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic emit(input logic [3:0] n);
        mem[ptr] = n;
        ptr = ptr + 1'b1;
    endtask

    // Monitor: compare each write strobe and each output change with the queue
    always @(negedge clk) begin
        if (running) begin
            if (wr_o) begin
                if (exp_q.size() == 0 || exp_q[0].is_out) begin
                    check(1'b0, "R4 R10 unexpected write", int'(addr_o), 0);
                end else begin
                    check(addr_o == exp_q[0].addr && data_o == exp_q[0].data && data_oe_o,
                          exp_q[0].req, {addr_o, data_o}, {exp_q[0].addr, exp_q[0].data});
                    void'(exp_q.pop_front());
                end
            end
            if (out_o !== prev_out) begin
                if (exp_q.size() == 0 || !exp_q[0].is_out) begin
                    check(1'b0, "R9 unexpected output change", int'(out_o), int'(prev_out));
                end else begin
                    check(out_o == exp_q[0].data, exp_q[0].req, out_o, exp_q[0].data);
                    void'(exp_q.pop_front());
                end
                prev_out = out_o;
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 4'h0;
        mem[8'h8D] = 4'hA;
        mem[8'h89] = 4'h8;
        ptr = 8'h00;
        emit(4'h6); emit(4'h8); emit(4'h0);   // 00 STAD 80
        emit(4'hC); emit(4'h8); emit(4'h1);   // 03 STXD 81
        emit(4'h0); emit(4'h9);               // 06 LDAI 9
        emit(4'h3); emit(4'h9);               // 08 ADDI 9 -> 2
        emit(4'h6); emit(4'h8); emit(4'h2);   // 0A STAD 82
        emit(4'h8); emit(4'h6);               // 0D NANDI 6 -> D
        emit(4'h6); emit(4'h8); emit(4'h3);   // 0F STAD 83
        emit(4'hA); emit(4'h3);               // 12 LDXI 3
        emit(4'hD); emit(4'hF);               // 14 UDXI F -> X=2
        emit(4'hC); emit(4'h8); emit(4'h4);   // 16 STXD 84
        emit(4'h2); emit(4'hF); emit(4'hF);   // 19 LDAX FF -> addr 01 = 8
        emit(4'h6); emit(4'h8); emit(4'h5);   // 1C STAD 85
        emit(4'h9); emit(4'h5);               // 1F OUTI 5
        emit(4'hB); emit(4'h8); emit(4'h3);   // 21 LDXD 83 -> X=D
        emit(4'h7); emit(4'h8); emit(4'h0);   // 24 OUTX 80 -> 8D = A
        emit(4'h4); emit(4'h7); emit(4'hC);   // 27 ADDX 7C -> 89, A=0
        emit(4'hF); emit(4'h4); emit(4'h0);   // 2A BEQ 40 (taken)
        emit(4'h9); emit(4'h1);               // 2D OUTI 1 (must be skipped)
        ptr = 8'h40;
        emit(4'h5); emit(4'h8); emit(4'h0);   // 40 NANDX 80 -> F
        emit(4'hF); emit(4'h2); emit(4'hD);   // 43 BEQ 2D (not taken)
        emit(4'h6); emit(4'h8); emit(4'h6);   // 46 STAD 86
        emit(4'h1); emit(4'h8); emit(4'h4);   // 49 LDAD 84 -> 2
        emit(4'h6); emit(4'h8); emit(4'h7);   // 4C STAD 87
        emit(4'hE); emit(4'h6); emit(4'h0);   // 4F BRA 60
        emit(4'h9); emit(4'h1);               // 52 OUTI 1 (must be skipped)
        ptr = 8'h60;
        emit(4'h9); emit(4'h3);               // 60 OUTI 3
        emit(4'hE); emit(4'h6); emit(4'h2);   // 62 BRA 62

        push_exp(1'b0, 8'h80, 4'h0, "R1 accumulator cleared by reset");
        push_exp(1'b0, 8'h81, 4'h0, "R1 index cleared by reset");
        push_exp(1'b0, 8'h82, 4'h2, "R2 add wraps modulo 16");
        push_exp(1'b0, 8'h83, 4'hD, "R3 NAND immediate");
        push_exp(1'b0, 8'h84, 4'h2, "R8 index update wraps");
        push_exp(1'b0, 8'h85, 4'h8, "R5 indexed address wraps modulo 256");
        push_exp(1'b1, 8'h00, 4'h5, "R9 immediate output");
        push_exp(1'b1, 8'h00, 4'hA, "R9 indexed output after direct index load R8");
        push_exp(1'b0, 8'h86, 4'hF, "R6 BEQ taken then not taken, NAND indexed R3");
        push_exp(1'b0, 8'h87, 4'h2, "R4 direct load and store");
        push_exp(1'b1, 8'h00, 4'h3, "R7 unconditional branch");

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(addr_o == 8'h00, "R1 reset address", addr_o, 0);
        check(rd_o == 1'b1, "R1 reset read strobe", rd_o, 1);
        check(wr_o == 1'b0 && data_oe_o == 1'b0, "R1 R10 no write after reset", wr_o, 0);
        check(out_o == 4'h0, "R1 output cleared", out_o, 0);
        prev_out = out_o;
        running = 1'b1;

        for (int c = 0; c < MAX_CYCLES && exp_q.size() != 0; c++) @(negedge clk);
        if (exp_q.size() != 0) begin
            check(1'b0, "watchdog: expected events missing", exp_q.size(), 0);
        end
        repeat (20) @(negedge clk);
        for (int c = 0; c < 6; c++) begin
            check(addr_o >= 8'h62 && addr_o <= 8'h64, "R7 branch to self loop", addr_o, 8'h62);
            check(!(rd_o && wr_o), "R10 strobes exclusive", {rd_o, wr_o}, 0);
            @(negedge clk);
        end
        check(mem[8'h8D] == 4'hA, "R10 no stray write", mem[8'h8D], 4'hA);
        check(out_o == 4'h3, "R9 output held", out_o, 3);
        running = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule